// File: doc/BRIEF.md
# Load-Use and Branch Stall Cycle Counter

This block does cycle accounting for an in-order core that can retire instructions one at a time or as a parallel pair. Each clock the core may present one retired instruction. The instruction carries:

- its class;
- up to two source register numbers, each with its own valid flag;
- a destination register;
- a taken flag for branches;
- a base cycle cost;
- flags marking it as the first and/or last instruction of its issue group.

The block tracks which general registers were written by loads. It charges a load-use penalty when a later instruction reads one of them, and a penalty for every taken branch. It keeps five saturating counters that software reads directly from the output ports:

- total cycles;
- branch-stall cycles;
- load-stall cycles;
- taken branches;
- untaken branches.

For a parallel pair, only the more expensive of the two instructions adds to the total cycle count, and each instruction's cost includes the stall cycles its group has gathered so far.

The block only counts. It never holds back the pipeline.

Top module: `stall_acct_top`

## Requirements
- R1: Class encoding is exec=0, compare=1, MAC=2, branch=3, load=4, store=5. Exec, compare, MAC and store check source A and source B; branch and load check only source A. Each checked source whose register bit is set in the committed loaded-register mask adds 2 load-stall cycles to the group, so a source pair that names the same loaded register adds 4.
- R2: A source whose valid flag is low is never checked and adds no stall.
- R3: A load sets the bit of its destination register in the pending mask. After every instruction the committed mask takes the pending mask's value. A load is therefore seen by the instruction after it (its pair partner, or the first instruction of the next group) and never by itself.
- R4: An instruction flagged first clears the group's branch-stall accumulator, load-stall accumulator, pending mask and running maximum before its own effects are applied. The accumulators carry over to the second instruction of a pair.
- R5: A taken branch adds 2 cycles to the group branch-stall accumulator and increments the taken count. An untaken branch increments the untaken count and adds no stall.
- R6: An instruction's cost is its base cycles plus the group's branch-stall and load-stall accumulators after its own effects.
- R7: An instruction not flagged last stores its cost as the running maximum and leaves the total cycle count unchanged. An instruction flagged last adds the larger of the running maximum and its own cost to the total cycle count.
- R8: After every instruction, the branch-stall total and the load-stall total each add the current value of the matching group accumulator. A stall in the first instruction of a pair is therefore counted again by its partner.
- R9: Every counter saturates at 2^CNT_W-1 and never wraps or decreases, except when cleared.
- R10: A high synchronous clear zeroes all counters, both masks, both group accumulators and the running maximum. It takes priority over an instruction presented in the same cycle.
- R11: After reset all counters read zero and both masks are empty.
- R12: Counters change at the clock edge at which the instruction is presented. A cycle without a valid instruction and without clear changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and tracking state |
| ins_valid | input | 1 | A retired instruction is presented this cycle |
| ins_class | input | 3 | Instruction class (encoding in R1) |
| src_a | input | $clog2(NREG) | Source A register number |
| src_a_vld | input | 1 | Source A is used |
| src_b | input | $clog2(NREG) | Source B register number |
| src_b_vld | input | 1 | Source B is used |
| dst_reg | input | $clog2(NREG) | Destination register number |
| br_taken | input | 1 | Branch was taken |
| base_cyc | input | BASE_W | Base cycle cost |
| grp_first | input | 1 | First instruction of its issue group |
| grp_last | input | 1 | Last instruction of its issue group |
| total_cycles | output | CNT_W | Accumulated cycles |
| branch_stall_total | output | CNT_W | Accumulated branch-stall cycles |
| load_stall_total | output | CNT_W | Accumulated load-stall cycles |
| taken_count | output | CNT_W | Number of taken branches |
| untaken_count | output | CNT_W | Number of untaken branches |

## Verification
A stale or wrongly cleared committed mask shows as a load-stall total that is 2 too high or too low, one edge after the first instruction that reads the affected register. The same error reaches the total cycle count once that group's last instruction retires.

A group accumulator that is not cleared on a first instruction inflates the next group's cost. A running maximum that is not cleared does the same, so the total cycle count shows the error at the end of the next group.

A lost pending-to-committed transfer hides a pair partner's load-use stall in the very next cycle. Saturation faults only show once a counter reaches its ceiling, which the bench reaches by using a narrow counter width.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;

    typedef enum logic [2:0] {
        CLS_EXEC   = 3'd0,
        CLS_CMP    = 3'd1,
        CLS_MAC    = 3'd2,
        CLS_BRANCH = 3'd3,
        CLS_LOAD   = 3'd4,
        CLS_STORE  = 3'd5
    } ins_class_e;

    localparam int NUM_CTR  = 5;
    localparam int IX_CYC   = 0;
    localparam int IX_BSTL  = 1;
    localparam int IX_LSTL  = 2;
    localparam int IX_TAKEN = 3;
    localparam int IX_UNTKN = 4;

    localparam int STALL_PER_HIT = 2;
    localparam int BR_PENALTY    = 2;

endpackage

// File: rtl/stall_hazard_chk.sv
module stall_hazard_chk #(
    parameter int NREG   = 16,
    parameter int RIDX_W = 4,
    parameter int ST_W   = 3
) (
    input  logic [NREG-1:0]        mask_q,
    input  logic [1:0][RIDX_W-1:0] src_idx,
    input  logic [1:0]             src_chk,
    output logic [ST_W-1:0]        stall_add
);
    import stall_acct_pkg::*;

    logic [1:0] hit;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_src
            assign hit[g] = src_chk[g] & mask_q[src_idx[g]];
        end
    endgenerate

    always_comb begin
        stall_add = ST_W'((32'(hit[0]) + 32'(hit[1])) * STALL_PER_HIT);
    end

endmodule

// File: rtl/stall_sat_ctr.sv
module stall_sat_ctr #(
    parameter int CNT_W = 32,
    parameter int IN_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [IN_W-1:0]  add_val,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = ((CNT_W > IN_W) ? CNT_W : IN_W) + 1;
    localparam logic [SUM_W-1:0] CAP = {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = SUM_W'(cnt_q) + SUM_W'(add_val);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (add_en) begin
            cnt_d = (sum > CAP) ? CAP[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    p_no_decrease_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q == CAP[CNT_W-1:0]) |=> (cnt_q == CAP[CNT_W-1:0]));

endmodule

// File: rtl/stall_acct_top.sv
module stall_acct_top #(
    parameter int NREG   = 16,
    parameter int CNT_W  = 32,
    parameter int BASE_W = 8,
    parameter int ACC_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    ins_valid,
    input  logic [2:0]              ins_class,
    input  logic [$clog2(NREG)-1:0] src_a,
    input  logic                    src_a_vld,
    input  logic [$clog2(NREG)-1:0] src_b,
    input  logic                    src_b_vld,
    input  logic [$clog2(NREG)-1:0] dst_reg,
    input  logic                    br_taken,
    input  logic [BASE_W-1:0]       base_cyc,
    input  logic                    grp_first,
    input  logic                    grp_last,
    output logic [CNT_W-1:0]        total_cycles,
    output logic [CNT_W-1:0]        branch_stall_total,
    output logic [CNT_W-1:0]        load_stall_total,
    output logic [CNT_W-1:0]        taken_count,
    output logic [CNT_W-1:0]        untaken_count
);
    import stall_acct_pkg::*;

    localparam int RIDX_W = $clog2(NREG);
    localparam int ST_W   = 3;
    localparam int TOT_W  = ((BASE_W > ACC_W) ? BASE_W : ACC_W) + 2;

    typedef struct packed {
        logic [NREG-1:0]  committed;
        logic [NREG-1:0]  pending;
        logic [ACC_W-1:0] br_acc;
        logic [ACC_W-1:0] ld_acc;
        logic [TOT_W-1:0] run_max;
    } trk_t;

    trk_t trk_d, trk_q;

    ins_class_e cls;
    logic       is_branch, is_load, chk_b;
    logic [ST_W-1:0]          ld_add;
    logic [1:0][RIDX_W-1:0]   src_idx;
    logic [1:0]               src_chk;

    logic [TOT_W-1:0]         cost, cyc_add;
    logic [NUM_CTR-1:0]       c_en;
    logic [TOT_W-1:0]         c_val [NUM_CTR];
    logic [CNT_W-1:0]         c_out [NUM_CTR];

    assign cls       = ins_class_e'(ins_class);
    assign is_branch = (cls == CLS_BRANCH);
    assign is_load   = (cls == CLS_LOAD);
    assign chk_b     = !(is_branch || is_load);
    assign src_idx   = {src_b, src_a};
    assign src_chk   = {src_b_vld & chk_b, src_a_vld};

    stall_hazard_chk #(
        .NREG   (NREG),
        .RIDX_W (RIDX_W),
        .ST_W   (ST_W)
    ) u_haz (
        .mask_q    (trk_q.committed),
        .src_idx   (src_idx),
        .src_chk   (src_chk),
        .stall_add (ld_add)
    );

    always_comb begin
        trk_d   = trk_q;
        cost    = '0;
        cyc_add = '0;
        c_en    = '0;
        for (int k = 0; k < NUM_CTR; k++) c_val[k] = '0;

        if (ins_valid) begin
            if (grp_first) begin
                trk_d.br_acc  = '0;
                trk_d.ld_acc  = '0;
                trk_d.pending = '0;
                trk_d.run_max = '0;
            end
            if (is_branch && br_taken) begin
                trk_d.br_acc = trk_d.br_acc + ACC_W'(BR_PENALTY);
            end
            trk_d.ld_acc = trk_d.ld_acc + ACC_W'(ld_add);
            if (is_load) begin
                trk_d.pending[dst_reg] = 1'b1;
            end
            cost = TOT_W'(base_cyc) + TOT_W'(trk_d.br_acc) + TOT_W'(trk_d.ld_acc);
            if (grp_last) begin
                cyc_add = (trk_d.run_max > cost) ? trk_d.run_max : cost;
            end else begin
                trk_d.run_max = cost;
            end
            trk_d.committed = trk_d.pending;

            c_en[IX_CYC]    = grp_last;
            c_val[IX_CYC]   = cyc_add;
            c_en[IX_BSTL]   = 1'b1;
            c_val[IX_BSTL]  = TOT_W'(trk_d.br_acc);
            c_en[IX_LSTL]   = 1'b1;
            c_val[IX_LSTL]  = TOT_W'(trk_d.ld_acc);
            c_en[IX_TAKEN]  = is_branch & br_taken;
            c_val[IX_TAKEN] = TOT_W'(1);
            c_en[IX_UNTKN]  = is_branch & ~br_taken;
            c_val[IX_UNTKN] = TOT_W'(1);
        end

        if (clr) begin
            trk_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_ctr
            stall_sat_ctr #(
                .CNT_W (CNT_W),
                .IN_W  (TOT_W)
            ) u_ctr (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr),
                .add_en  (c_en[g]),
                .add_val (c_val[g]),
                .cnt     (c_out[g])
            );
        end
    endgenerate

    assign total_cycles       = c_out[IX_CYC];
    assign branch_stall_total = c_out[IX_BSTL];
    assign load_stall_total   = c_out[IX_LSTL];
    assign taken_count        = c_out[IX_TAKEN];
    assign untaken_count      = c_out[IX_UNTKN];

    p_empty_mask_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.committed == '0) |-> (ld_add == '0));

    p_mid_group_cycles_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !grp_last && !clr) |=> $stable(total_cycles));

    p_nonbranch_counts_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ins_valid && is_branch) && !clr) |=> ($stable(taken_count) && $stable(untaken_count)));

    p_clear_zeroes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total_cycles == '0 && load_stall_total == '0 && branch_stall_total == '0
                 && taken_count == '0 && untaken_count == '0 && trk_q.committed == '0));

    p_idle_no_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !clr) |=> ($stable(total_cycles) && $stable(load_stall_total)
                                  && $stable(branch_stall_total)));

endmodule

// File: tb/sim_stall_acct_top.sv
module sim_stall_acct_top;

    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic ins_valid = 1'b0;
    logic [2:0] ins_class = '0;
    logic [3:0] src_a = '0, src_b = '0, dst_reg = '0;
    logic src_a_vld = 1'b0, src_b_vld = 1'b0, br_taken = 1'b0;
    logic [7:0] base_cyc = '0;
    logic grp_first = 1'b0, grp_last = 1'b0;
    logic [CW-1:0] total_cycles, branch_stall_total, load_stall_total, taken_count, untaken_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stall_acct_top #(.NREG(16), .CNT_W(CW), .BASE_W(8), .ACC_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ins_valid(ins_valid), .ins_class(ins_class),
        .src_a(src_a), .src_a_vld(src_a_vld), .src_b(src_b), .src_b_vld(src_b_vld),
        .dst_reg(dst_reg), .br_taken(br_taken), .base_cyc(base_cyc),
        .grp_first(grp_first), .grp_last(grp_last),
        .total_cycles(total_cycles), .branch_stall_total(branch_stall_total),
        .load_stall_total(load_stall_total), .taken_count(taken_count),
        .untaken_count(untaken_count)
    );

    typedef struct packed {
        logic [2:0] cls;
        logic [3:0] sa;
        logic       sav;
        logic [3:0] sb;
        logic       sbv;
        logic [3:0] dst;
        logic       tkn;
        logic [7:0] base;
        logic       gf;
        logic       gl;
        logic [7:0] ec;
        logic [7:0] eb;
        logic [7:0] el;
        logic [7:0] et;
        logic [7:0] eu;
    } row_t;

    localparam int NV = 22;
    // cls: exec=0 cmp=1 mac=2 branch=3 load=4 store=5
    localparam row_t TBL [NV] = '{
        '{3'd4, 4'd1, 1'b1, 4'd0, 1'b0, 4'd3, 1'b0, 8'd1, 1'b1, 1'b1,  8'd1, 8'd0,  8'd0, 8'd0, 8'd0}, // R3 load r3
        '{3'd0, 4'd3, 1'b1, 4'd5, 1'b1, 4'd0, 1'b0, 8'd1, 1'b1, 1'b1,  8'd4, 8'd0,  8'd2, 8'd0, 8'd0}, // R1 R6 use r3
        '{3'd0, 4'd3, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 8'd1, 1'b1, 1'b1,  8'd5, 8'd0,  8'd2, 8'd0, 8'd0}, // R3 mask now empty
        '{3'd3, 4'd2, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 8'd1, 1'b1, 1'b1,  8'd8, 8'd2,  8'd2, 8'd1, 8'd0}, // R5 taken
        '{3'd3, 4'd2, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 8'd1, 1'b1, 1'b1,  8'd9, 8'd2,  8'd2, 8'd1, 8'd1}, // R5 untaken
        '{3'd4, 4'd0, 1'b1, 4'd0, 1'b0, 4'd7, 1'b0, 8'd1, 1'b1, 1'b0,  8'd9, 8'd2,  8'd2, 8'd1, 8'd1}, // R7 pair first
        '{3'd5, 4'd7, 1'b1, 4'd2, 1'b1, 4'd0, 1'b0, 8'd1, 1'b0, 1'b1, 8'd12, 8'd2,  8'd4, 8'd1, 8'd1}, // R3 R7 partner sees load
        '{3'd2, 4'd4, 1'b1, 4'd7, 1'b1, 4'd0, 1'b0, 8'd2, 1'b1, 1'b1, 8'd16, 8'd2,  8'd6, 8'd1, 8'd1}, // R1 mac src B
        '{3'd3, 4'd1, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 8'd1, 1'b1, 1'b0, 8'd16, 8'd4,  8'd6, 8'd2, 8'd1}, // R8 pair taken
        '{3'd0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 8'd1, 1'b0, 1'b1, 8'd19, 8'd6,  8'd6, 8'd2, 8'd1}, // R4 R8 acc carries
        '{3'd1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 8'd5, 1'b1, 1'b0, 8'd19, 8'd6,  8'd6, 8'd2, 8'd1}, // R4 cleared on first
        '{3'd0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 8'd2, 1'b0, 1'b1, 8'd24, 8'd6,  8'd6, 8'd2, 8'd1}, // R7 larger first
        '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd9, 1'b0, 8'd1, 1'b1, 1'b1, 8'd25, 8'd6,  8'd6, 8'd2, 8'd1}, // load r9
        '{3'd0, 4'd9, 1'b0, 4'd9, 1'b0, 4'd0, 1'b0, 8'd1, 1'b1, 1'b1, 8'd26, 8'd6,  8'd6, 8'd2, 8'd1}, // R2 invalid srcs
        '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd4, 1'b0, 8'd1, 1'b1, 1'b1, 8'd27, 8'd6,  8'd6, 8'd2, 8'd1}, // load r4
        '{3'd1, 4'd0, 1'b1, 4'd4, 1'b1, 4'd0, 1'b0, 8'd1, 1'b1, 1'b1, 8'd30, 8'd6,  8'd8, 8'd2, 8'd1}, // R1 cmp src B
        '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd6, 1'b0, 8'd1, 1'b1, 1'b1, 8'd31, 8'd6,  8'd8, 8'd2, 8'd1}, // load r6
        '{3'd3, 4'd1, 1'b1, 4'd6, 1'b1, 4'd0, 1'b0, 8'd1, 1'b1, 1'b1, 8'd32, 8'd6,  8'd8, 8'd2, 8'd2}, // R1 branch ignores B
        '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd8, 1'b0, 8'd1, 1'b1, 1'b1, 8'd33, 8'd6,  8'd8, 8'd2, 8'd2}, // load r8
        '{3'd0, 4'd8, 1'b1, 4'd8, 1'b1, 4'd0, 1'b0, 8'd1, 1'b1, 1'b1, 8'd38, 8'd6, 8'd12, 8'd2, 8'd2}, // R1 both srcs hit
        '{3'd4, 4'd5, 1'b1, 4'd0, 1'b0, 4'd5, 1'b0, 8'd1, 1'b1, 1'b1, 8'd39, 8'd6, 8'd12, 8'd2, 8'd2}, // R3 not self
        '{3'd0, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 8'd1, 1'b1, 1'b1, 8'd42, 8'd6, 8'd14, 8'd2, 8'd2}  // R3 next sees it
    };

    task automatic drive(input row_t r);
        ins_valid = 1'b1;
        ins_class = r.cls;
        src_a = r.sa;  src_a_vld = r.sav;
        src_b = r.sb;  src_b_vld = r.sbv;
        dst_reg = r.dst; br_taken = r.tkn;
        base_cyc = r.base; grp_first = r.gf; grp_last = r.gl;
    endtask

    task automatic check(input string req, input logic [7:0] ec, eb, el, et, eu);
        logic [39:0] act, exp_v;
        act   = {total_cycles, branch_stall_total, load_stall_total, taken_count, untaken_count};
        exp_v = {ec, eb, el, et, eu};
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: cyc/bst/lst/tk/ut actual %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
                     req, act[39:32], act[31:24], act[23:16], act[15:8], act[7:0],
                     ec, eb, el, et, eu);
        end
    endtask

    function automatic row_t mk(input logic [2:0] c, input logic [3:0] sa, input logic sav,
                                input logic [3:0] d, input logic [7:0] b);
        row_t r;
        r = '0;
        r.cls = c; r.sa = sa; r.sav = sav; r.dst = d; r.base = b; r.gf = 1'b1; r.gl = 1'b1;
        return r;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset state", 0, 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check($sformatf("R1-table row %0d (R6 R7)", i), TBL[i].ec, TBL[i].eb, TBL[i].el, TBL[i].et, TBL[i].eu);
        end

        // R12: idle cycle leaves every counter as is
        ins_valid = 1'b0;
        @(negedge clk);
        check("R12 idle", 42, 6, 14, 2, 2);

        // R10: clear wins over a simultaneous load of r3
        drive(mk(3'd4, 4'd0, 1'b0, 4'd3, 8'd1));
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R10 clear", 0, 0, 0, 0, 0);
        drive(mk(3'd0, 4'd3, 1'b1, 4'd0, 8'd1));
        @(negedge clk);
        check("R10 mask cleared", 1, 0, 0, 0, 0);

        // R9: saturation at 255 with CNT_W = 8
        drive(mk(3'd0, 4'd0, 1'b0, 4'd0, 8'd200));
        @(negedge clk);
        check("R9 below cap", 201, 0, 0, 0, 0);
        @(negedge clk);
        check("R9 saturate", 255, 0, 0, 0, 0);
        drive(mk(3'd0, 4'd0, 1'b0, 4'd0, 8'd1));
        @(negedge clk);
        check("R9 hold at cap", 255, 0, 0, 0, 0);
        ins_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule